// File: doc/BRIEF.md
# Storage Entry Vulnerability Lifetime Tracker

This block watches the event stream of a single address-based storage entry, such as a cache line, a translation entry or a store-buffer slot. It splits the entry's life into intervals bounded by events and assigns each closed interval to one of three classes: ACE time, when a bit flip would have reached program output; unACE time, when it would not; and unknown time, when the run ended before the interval could be resolved. A running cycle count is kept for each class.

The class of an interval is only known when the event that ends it arrives. A read closes its interval as ACE or unACE depending on whether the consuming instruction is ACE. Writes and idle periods close as unACE. An eviction or flush closes its interval as ACE only on a dirty write-back line. Any valid interval still open at end of run becomes unknown time. A flush issued together with end of run resolves that interval first, so no unknown time is recorded. After end of run the counters freeze and `done` rises, so a performance model can read the three counts and form a vulnerability ratio.

Top module: `ace_lifetime_tracker`

## Requirements
- R1: After synchronous reset the three counters read 0, `done` is 0 and the entry is idle (invalid, clean). Cycle time is counted from 0 at the first clock edge after reset is released.
- R2: Time while the entry is idle is added to the unACE counter when a fill ends it, or when end of run ends it.
- R3: A read of a valid entry with `rd_by_ace`=1 adds the interval it closes (since the last fill, read, write or eviction) to the ACE counter.
- R4: A read of a valid entry with `rd_by_ace`=0 adds the interval it closes to the unACE counter.
- R5: A write to a valid entry adds the interval it closes to the unACE counter and sets the internal dirty bit. A read or write to an idle entry has no effect.
- R6: With `mode_wb`=0 (write-through), the interval closed by an eviction or a flush is unACE, whatever the dirty state.
- R7: With `mode_wb`=1 (write-back), the interval closed by an eviction or a flush is ACE if the internal dirty bit or `line_dirty` is 1, and unACE otherwise.
- R8: A flush classifies exactly like an eviction, returns the entry to idle and clears the dirty bit. A fill to a valid entry without an eviction closes its interval as an eviction would, and leaves the entry valid and clean.
- R9: End of run adds an open valid interval to the unknown counter and sets `done`. From then until reset, `done` stays 1 and no counter changes.
- R10: A flush in the same cycle as end of run resolves the open interval as an eviction, so the unknown counter does not grow.
- R11: Events in one cycle are applied in the order evict/flush, fill, read, write, end of run. Only the first event that applies receives the elapsed interval; the rest close zero-length intervals but still update the state.
- R12: Each counter saturates at its maximum value (all ones, `CNT_W` bits) instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_wb | input | 1 | 1 = write-back policy, 0 = write-through |
| line_dirty | input | 1 | Dirty status of the line from the host structure |
| ev_fill | input | 1 | Fill strobe |
| ev_read | input | 1 | Read strobe |
| rd_by_ace | input | 1 | The read in this cycle is consumed by an ACE instruction |
| ev_write | input | 1 | Write strobe |
| ev_evict | input | 1 | Eviction strobe |
| ev_flush | input | 1 | Flush strobe |
| ev_end | input | 1 | End-of-run strobe |
| ace_cycles | output | CNT_W | Accumulated ACE cycles |
| unace_cycles | output | CNT_W | Accumulated unACE cycles |
| unknown_cycles | output | CNT_W | Accumulated unknown cycles |
| done | output | 1 | Final classification complete |

## Verification
The bench builds the tracker with `CNT_W`=8 and `TIME_W`=16. The narrow counters let one idle stretch of a few hundred cycles drive a counter into saturation, which brings R12 within reach inside a short run. The 16-bit time base still covers every interval the bench creates. Directed sequences under both write policies cover each closing rule, and a random phase stacks several strobes in one cycle to test the ordering rule.

// File: rtl/ace_lt_pkg.sv
// Shared types for the lifetime tracker.
// Assumes: one class code is produced per cycle, CLS_NONE when no interval closes.
package ace_lt_pkg;
    typedef enum logic [1:0] {
        CLS_NONE    = 2'd0,
        CLS_ACE     = 2'd1,
        CLS_UNACE   = 2'd2,
        CLS_UNKNOWN = 2'd3
    } ival_cls_e;

    localparam int NUM_CLS = 3;
endpackage

// File: rtl/ace_lt_classifier.sv
// Combinational event resolver. It applies this cycle's strobes in fixed order
// (evict/flush, fill, read, write, end). It reports the class of the interval
// closed by the first event that applies, plus the next valid and dirty state.
// Assumes: the caller gates everything once the run has ended.
module ace_lt_classifier
    import ace_lt_pkg::*;
(
    input  logic      valid_q,
    input  logic      dirty_q,
    input  logic      line_dirty,
    input  logic      mode_wb,
    input  logic      ev_fill,
    input  logic      ev_read,
    input  logic      rd_by_ace,
    input  logic      ev_write,
    input  logic      ev_evict,
    input  logic      ev_flush,
    input  logic      ev_end,
    output ival_cls_e cls,
    output logic      valid_n,
    output logic      dirty_n,
    output logic      end_seen
);
    ival_cls_e retire_cls;

    // Class of an interval ended by removal of the line's contents.
    always_comb begin
        retire_cls = (mode_wb && (dirty_q || line_dirty)) ? CLS_ACE : CLS_UNACE;
    end

    // Ordered walk over the strobes; the first applicable one takes the interval.
    always_comb begin
        cls      = CLS_NONE;
        valid_n  = valid_q;
        dirty_n  = dirty_q;
        end_seen = ev_end;
        if (ev_evict || ev_flush) begin
            if (valid_n) begin
                cls = retire_cls;
            end
            valid_n = 1'b0;
            dirty_n = 1'b0;
        end
        if (ev_fill) begin
            if (cls == CLS_NONE) begin
                cls = valid_n ? retire_cls : CLS_UNACE;
            end
            valid_n = 1'b1;
            dirty_n = 1'b0;
        end
        if (ev_read && valid_n) begin
            if (cls == CLS_NONE) begin
                cls = rd_by_ace ? CLS_ACE : CLS_UNACE;
            end
        end
        if (ev_write && valid_n) begin
            if (cls == CLS_NONE) begin
                cls = CLS_UNACE;
            end
            dirty_n = 1'b1;
        end
        if (ev_end) begin
            if (cls == CLS_NONE) begin
                cls = valid_n ? CLS_UNKNOWN : CLS_UNACE;
            end
        end
    end
endmodule

// File: rtl/ace_lt_sat_acc.sv
// Saturating accumulator for one time class.
// Assumes: add_len is the length of the interval closed this cycle; hold freezes it.
module ace_lt_sat_acc #(
    parameter int CNT_W = 32,
    parameter int LEN_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             add_en,
    input  logic [LEN_W-1:0] add_len,
    output logic [CNT_W-1:0] count
);
    localparam int SUM_W = ((CNT_W > LEN_W) ? CNT_W : LEN_W) + 1;
    localparam logic [CNT_W-1:0] CMAX = '1;

    logic [SUM_W-1:0] sum;

    // Wide sum so that an overflow can be seen before clamping.
    always_comb begin
        sum = SUM_W'(count) + SUM_W'(add_len);
    end

    // Accumulate, clamping at the all-ones value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (add_en && !hold) begin
            if (sum > SUM_W'(CMAX)) begin
                count <= CMAX;
            end else begin
                count <= sum[CNT_W-1:0];
            end
        end
    end

    p_no_decrease_r12: assert property (@(posedge clk) disable iff (!rst_n)
        count >= $past(count));
    p_sat_holds_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CMAX) |=> (count == CMAX));
endmodule

// File: rtl/ace_lifetime_tracker.sv
// Lifetime tracker top. It keeps a free-running cycle count, the start cycle
// of the open interval, and the entry's valid and dirty bits. On each closing
// event it credits the elapsed cycles to one of three class counters.
// Assumes: a run is shorter than 2**TIME_W cycles; after end of run all state
// is frozen until reset.
module ace_lifetime_tracker
    import ace_lt_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int TIME_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_wb,
    input  logic             line_dirty,
    input  logic             ev_fill,
    input  logic             ev_read,
    input  logic             rd_by_ace,
    input  logic             ev_write,
    input  logic             ev_evict,
    input  logic             ev_flush,
    input  logic             ev_end,
    output logic [CNT_W-1:0] ace_cycles,
    output logic [CNT_W-1:0] unace_cycles,
    output logic [CNT_W-1:0] unknown_cycles,
    output logic             done
);
    localparam logic [TIME_W-1:0] TMAX = '1;

    logic [TIME_W-1:0] now_q;
    logic [TIME_W-1:0] start_q;
    logic [TIME_W-1:0] ival_len;
    logic              valid_q;
    logic              dirty_q;
    logic              valid_n;
    logic              dirty_n;
    logic              end_seen;
    ival_cls_e         cls;
    logic [CNT_W-1:0]  counts [NUM_CLS];

    ace_lt_classifier u_cls (
        .valid_q    (valid_q),
        .dirty_q    (dirty_q),
        .line_dirty (line_dirty),
        .mode_wb    (mode_wb),
        .ev_fill    (ev_fill),
        .ev_read    (ev_read),
        .rd_by_ace  (rd_by_ace),
        .ev_write   (ev_write),
        .ev_evict   (ev_evict),
        .ev_flush   (ev_flush),
        .ev_end     (ev_end),
        .cls        (cls),
        .valid_n    (valid_n),
        .dirty_n    (dirty_n),
        .end_seen   (end_seen)
    );

    // Length of the interval that would close in this cycle.
    always_comb begin
        ival_len = now_q - start_q;
    end

    // Time base, interval start, entry state and end-of-run flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            now_q   <= '0;
            start_q <= '0;
            valid_q <= 1'b0;
            dirty_q <= 1'b0;
            done    <= 1'b0;
        end else if (!done) begin
            if (now_q != TMAX) begin
                now_q <= now_q + 1'b1;
            end
            if (cls != CLS_NONE) begin
                start_q <= now_q;
            end
            valid_q <= valid_n;
            dirty_q <= dirty_n;
            done    <= end_seen;
        end
    end

    // One saturating accumulator per class; class code i+1 feeds slot i.
    for (genvar gi = 0; gi < NUM_CLS; gi++) begin : g_acc
        ace_lt_sat_acc #(
            .CNT_W (CNT_W),
            .LEN_W (TIME_W)
        ) u_acc (
            .clk     (clk),
            .rst_n   (rst_n),
            .hold    (done),
            .add_en  (cls == ival_cls_e'(gi + 1)),
            .add_len (ival_len),
            .count   (counts[gi])
        );
    end

    assign ace_cycles     = counts[0];
    assign unace_cycles   = counts[1];
    assign unknown_cycles = counts[2];

    p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);
    p_frozen_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> ($stable(ace_cycles) && $stable(unace_cycles) && $stable(unknown_cycles)));
    p_unknown_needs_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_end |=> $stable(unknown_cycles));
    p_flush_end_known_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_end && ev_flush) |=> $stable(unknown_cycles));
    p_idle_fill_not_ace_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_q && ev_fill) |=> $stable(ace_cycles));
    p_wt_evict_not_ace_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_wb && (ev_evict || ev_flush)) |=> $stable(ace_cycles));
    p_one_class_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({ace_cycles != $past(ace_cycles),
                    unace_cycles != $past(unace_cycles),
                    unknown_cycles != $past(unknown_cycles)}) <= 1);
endmodule

// File: tb/tb_ace_lifetime_tracker.sv
module tb_ace_lifetime_tracker;
    localparam int CNT_W  = 8;
    localparam int TIME_W = 16;
    localparam int CMAXI  = (1 << CNT_W) - 1;
    localparam int TMAXI  = (1 << TIME_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_wb = 1'b0, line_dirty = 1'b0;
    logic ev_fill = 1'b0, ev_read = 1'b0, rd_by_ace = 1'b0, ev_write = 1'b0;
    logic ev_evict = 1'b0, ev_flush = 1'b0, ev_end = 1'b0;
    logic [CNT_W-1:0] ace_cycles, unace_cycles, unknown_cycles;
    logic done;

    always #2.5 clk = ~clk;

    ace_lifetime_tracker #(.CNT_W(CNT_W), .TIME_W(TIME_W)) dut (
        .clk(clk), .rst_n(rst_n), .mode_wb(mode_wb), .line_dirty(line_dirty),
        .ev_fill(ev_fill), .ev_read(ev_read), .rd_by_ace(rd_by_ace),
        .ev_write(ev_write), .ev_evict(ev_evict), .ev_flush(ev_flush),
        .ev_end(ev_end), .ace_cycles(ace_cycles), .unace_cycles(unace_cycles),
        .unknown_cycles(unknown_cycles), .done(done)
    );

    int n_cmp = 0;
    int n_bad = 0;
    string cur_req = "R1";

    // Behavioural reference: totals[0]=ACE, [1]=unACE, [2]=unknown.
    int  totals[3];
    int  m_now, m_start;
    bit  m_valid, m_dirty, m_done;

    function automatic void model_reset();
        foreach (totals[i]) totals[i] = 0;
        m_now = 0; m_start = 0;
        m_valid = 0; m_dirty = 0; m_done = 0;
    endfunction

    function automatic void model_step(bit f, bit r, bit ra, bit w, bit e, bit fl, bit en);
        int kind = -1;
        int span;
        int retire;
        if (m_done) return;
        span = m_now - m_start;
        retire = (mode_wb && (m_dirty || line_dirty)) ? 0 : 1;
        if (e || fl) begin
            if (m_valid) kind = retire;
            m_valid = 0; m_dirty = 0;
        end
        if (f) begin
            if (kind < 0) kind = m_valid ? retire : 1;
            m_valid = 1; m_dirty = 0;
        end
        if (r && m_valid && kind < 0) kind = ra ? 0 : 1;
        if (w && m_valid) begin
            if (kind < 0) kind = 1;
            m_dirty = 1;
        end
        if (en) begin
            if (kind < 0) kind = m_valid ? 2 : 1;
            m_done = 1;
        end
        if (kind >= 0) begin
            totals[kind] = (totals[kind] + span > CMAXI) ? CMAXI : totals[kind] + span;
            m_start = m_now;
        end
        if (m_now < TMAXI) m_now++;
    endfunction

    task automatic check_outputs();
        n_cmp++;
        if (ace_cycles !== CNT_W'(totals[0]) || unace_cycles !== CNT_W'(totals[1]) ||
            unknown_cycles !== CNT_W'(totals[2]) || done !== m_done) begin
            n_bad++;
            $display("FAIL %s: got ace=%0d unace=%0d unk=%0d done=%0b, expected ace=%0d unace=%0d unk=%0d done=%0b",
                     cur_req, ace_cycles, unace_cycles, unknown_cycles, done,
                     totals[0], totals[1], totals[2], m_done);
        end
    endtask

    // Compare, drive one cycle of strobes, advance the model, wait for the edge.
    task automatic step(bit f, bit r, bit ra, bit w, bit e, bit fl, bit en);
        check_outputs();
        ev_fill = f; ev_read = r; rd_by_ace = ra; ev_write = w;
        ev_evict = e; ev_flush = fl; ev_end = en;
        model_step(f, r, ra, w, e, fl, en);
        @(negedge clk);
    endtask

    task automatic quiet(int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic do_reset();
        rst_n = 0;
        {ev_fill, ev_read, rd_by_ace, ev_write, ev_evict, ev_flush, ev_end} = '0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        model_reset();
    endtask

    task automatic expect_val(string req, int got, int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    initial begin
        #(5ns * 150000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        cur_req = "R1";
        check_outputs();
        expect_val("R1", int'(ace_cycles) + int'(unace_cycles) + int'(unknown_cycles), 0);

        // R2: idle then fill, and idle closed by end of run.
        cur_req = "R2";
        quiet(5); step(1,0,0,0,0,0,0); quiet(2);
        do_reset(); quiet(4); step(0,0,0,0,0,0,1); quiet(2);

        // R3 and R4: reads by ACE and unACE consumers.
        do_reset(); mode_wb = 0;
        cur_req = "R3"; step(1,0,0,0,0,0,0); quiet(3); step(0,1,1,0,0,0,0);
        quiet(2); step(0,1,1,0,0,0,0);
        cur_req = "R4"; quiet(4); step(0,1,0,0,0,0,0); quiet(1);

        // R5: write on valid line; read and write on idle line ignored.
        cur_req = "R5"; quiet(3); step(0,0,0,1,0,0,0); quiet(2);
        step(0,0,0,0,1,0,0); quiet(3);
        step(0,1,1,0,0,0,0); step(0,0,0,1,0,0,0); quiet(2);
        step(1,0,0,0,0,0,0); quiet(2);

        // R6: write-through eviction of a written line stays unACE.
        do_reset(); mode_wb = 0; cur_req = "R6";
        step(1,0,0,0,0,0,0); quiet(1); step(0,0,0,1,0,0,0); quiet(4);
        step(0,0,0,0,1,0,0); quiet(2);
        line_dirty = 1; step(1,0,0,0,0,0,0); quiet(3); step(0,0,0,0,0,1,0); quiet(1);
        line_dirty = 0;

        // R7: write-back eviction, dirty by write, dirty by input, clean.
        do_reset(); mode_wb = 1; cur_req = "R7";
        step(1,0,0,0,0,0,0); step(0,0,0,1,0,0,0); quiet(5); step(0,0,0,0,1,0,0);
        quiet(2); step(1,0,0,0,0,0,0); quiet(3);
        line_dirty = 1; step(0,0,0,0,1,0,0); line_dirty = 0;
        step(1,0,0,0,0,0,0); quiet(3); step(0,0,0,0,1,0,0); quiet(1);

        // R8: flush like evict, clears dirty; fill on valid line replaces.
        cur_req = "R8";
        step(1,0,0,0,0,0,0); step(0,0,0,1,0,0,0); quiet(3); step(0,0,0,0,0,1,0);
        quiet(2); step(1,0,0,0,0,0,0); quiet(3); step(1,0,0,0,0,0,0);
        quiet(2); step(0,0,0,0,1,0,0); quiet(1);
        step(1,0,0,0,0,0,0); step(0,0,0,1,0,0,0); quiet(2); step(1,0,0,0,0,0,0);
        quiet(2); step(0,0,0,0,1,0,0); quiet(1);

        // R9: end with an open valid interval, then everything frozen.
        cur_req = "R9";
        step(1,0,0,0,0,0,0); quiet(4); step(0,0,0,0,0,0,1);
        step(0,1,1,0,0,0,0); step(0,0,0,0,1,0,0); step(1,0,0,1,0,0,1); quiet(3);
        expect_val("R9", int'(done), 1);

        // R10: flush together with end leaves no unknown time.
        do_reset(); mode_wb = 1; cur_req = "R10";
        step(1,0,0,0,0,0,0); step(0,0,0,1,0,0,0); quiet(6); step(0,0,0,0,0,1,1);
        quiet(2);
        expect_val("R10", int'(unknown_cycles), 0);

        // R11: stacked strobes in one cycle, random over both policies.
        for (int pass = 0; pass < 6; pass++) begin
            do_reset(); mode_wb = pass[0]; cur_req = "R11";
            step(1,1,1,1,0,0,0); quiet(2); step(1,1,1,1,1,0,0); quiet(3);
            step(0,1,0,1,0,1,0); step(1,1,0,0,0,0,0);
            for (int k = 0; k < 300; k++) begin
                int p = $urandom_range(0, 99);
                line_dirty = ($urandom_range(0, 9) == 0);
                step(p < 15, p >= 10 && p < 45, $urandom_range(0, 1) == 1,
                     p >= 40 && p < 60, p >= 58 && p < 66, p >= 64 && p < 70, 0);
            end
            line_dirty = 0;
            step(0,0,0,0,0,pass[1],1); quiet(2);
        end

        // R12: a long idle stretch saturates the unACE counter.
        do_reset(); mode_wb = 0; cur_req = "R12";
        quiet(300); step(1,0,0,0,0,0,0); quiet(1);
        expect_val("R12", int'(unace_cycles), CMAXI);
        quiet(20); step(0,1,0,0,0,0,0); quiet(1);
        expect_val("R12", int'(unace_cycles), CMAXI);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule